// File: doc/BRIEF.md
# Transmit Rate-Adapting FIFO

This block is a small transmit buffer between user logic and a 64B/66B encoder. Both sides run on one clock. The encoder side takes a word on only 32 of every 33 cycles, which matches its 64/66 bandwidth, so the writer has to be slowed by about one word in 33. Each entry holds 64 bits of XGMII data and 8 bits of XGMII control. Entries leave in the order they were written.

The writer can be throttled in either of two ways. The first uses the programmable almost-full flag: when the flag rises, the writer stops in the next cycle. The second uses the built-in write pacer. The pacer closes the write path for one cycle in every 33, so the write enable may be held high continuously without watching any flag. Programmable almost-full and almost-empty levels, full and empty status, and sticky overflow and underflow indications report the fill state.

Top module: `tx_rate_fifo`

## Requirements
- R1: Each entry is 72 bits: control in bits [71:64] and data in bits [63:0]. Entries are read out in write order. The word for an accepted read appears on `rd_ctrl`/`rd_data` directly after the clock edge at which `rd_en` was sampled.
- R2: After reset, `empty` and `almost_empty` are 1. `full`, `almost_full`, `overflow` and `underflow` are 0, and the read outputs are zero.
- R3: `almost_full` is 1 exactly when the registered occupancy is greater than or equal to `afull_lvl`. `afull_lvl` is an unsigned entry count from 0 to 16.
- R4: `almost_empty` is 1 exactly when the occupancy is less than or equal to `aempty_lvl`. `aempty_lvl` is an unsigned entry count.
- R5: `full` is 1 at 16 entries. A write while `full` is 1 is dropped, even if a read happens in the same cycle. The dropped write sets `overflow`, which stays set until reset.
- R6: A read while `empty` is 1 leaves the read outputs unchanged. It sets `underflow`, which stays set until reset.
- R7: While `pace_en` is 1, a 6-bit counter steps 0,1,…,32,0. A write presented while the counter is at 32 is ignored. While `pace_en` is 0, the counter is held at 0, so the first cycle with `pace_en` high uses count 0.
- R8: With `pace_en` low, every write presented while the FIFO is not full is stored. A write enable held high against a reader that reads every cycle loses no word.
- R9: With the pacer on and the write enable held high, a reader that idles one cycle in every 33 receives every accepted word in order. Neither overflow nor underflow occurs.
- R10: A writer that stops in the cycle after it sees `almost_full` rise never overflows when `afull_lvl` is below 16. Occupancy settles exactly at `afull_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by writer and encoder side |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 64 | XGMII data to store |
| wr_ctrl | input | 8 | XGMII control to store |
| pace_en | input | 1 | Enables the one-in-33 write pacer |
| rd_en | input | 1 | Read request from the encoder side |
| afull_lvl | input | 5 | Almost-full occupancy level |
| aempty_lvl | input | 5 | Almost-empty occupancy level |
| rd_data | output | 64 | Data of the last word read |
| rd_ctrl | output | 8 | Control of the last word read |
| full | output | 1 | FIFO holds 16 entries |
| empty | output | 1 | FIFO holds no entries |
| almost_full | output | 1 | Occupancy at or above `afull_lvl` |
| almost_empty | output | 1 | Occupancy at or below `aempty_lvl` |
| overflow | output | 1 | Sticky: a write was dropped |
| underflow | output | 1 | Sticky: a read found the FIFO empty |

## Verification
The bench places writes on pacer counts 30, 31, 32 and 0. If the gap landed on the wrong count, or the counter were not held at zero while the pacer is disabled, the bench would read back the wrong three words.

It writes a seventeenth word into a full FIFO and then drains it. A design that overwrote an entry or dropped the sticky overflow would return corrupted data or lose the flag. It also reads from an empty FIFO, and a design that advanced its read pointer there would change the held output.

Long streams check two cases: the pacer against a reader that idles one cycle in 33, and an unpaced writer against a reader that reads every cycle. An off-by-one in the pointer wrap or the occupancy count would show up as a reordered word, a missing word or a spurious overflow. The flag-throttled writer catches an almost-full flag that rises one entry late.

// File: rtl/txfifo_pkg.sv
package txfifo_pkg;

    localparam int DATA_W = 64;
    localparam int CTRL_W = 8;

    // one stored word: control above data
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] data;
    } entry_t;

endpackage

// File: rtl/txfifo_pacer.sv
module txfifo_pacer #(
    parameter int PERIOD = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pace_en,
    input  logic wr_req,
    output logic wr_ok
);

    generate
        if (PERIOD > 1) begin : g_paced
            localparam int CW = $clog2(PERIOD);
            localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

            typedef struct packed {
                logic [CW-1:0] cnt;
            } pace_t;

            pace_t s_d, s_q;

            always_comb begin
                s_d = s_q;
                if (!pace_en) begin
                    s_d.cnt = '0;
                end else if (s_q.cnt == LAST) begin
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
                // the last slot of each period is closed to writes
                wr_ok = wr_req && !(pace_en && (s_q.cnt == LAST));
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s_q <= '0;
                end else begin
                    s_q <= s_d;
                end
            end

            // R7: counter never leaves its range
            a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.cnt <= LAST);
            // R7: wrap after the closed slot
            a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
                (pace_en && s_q.cnt == LAST) |=> (s_q.cnt == '0));
            // R7: held at zero while disabled
            a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
                !pace_en |=> (s_q.cnt == '0));
        end else begin : g_bypass
            assign wr_ok = wr_req;
        end
    endgenerate

endmodule

// File: rtl/txfifo_ctrl.sv
module txfifo_ctrl #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic [LW-1:0] afull_lvl,
    input  logic [LW-1:0] aempty_lvl,
    output logic          push,
    output logic          pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty,
    output logic          overflow,
    output logic          underflow
);

    localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] cnt;
        logic          ovf;
        logic          udf;
    } ctl_t;

    ctl_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        full         = (s_q.cnt == FULL_CNT);
        empty        = (s_q.cnt == '0);
        almost_full  = (s_q.cnt >= afull_lvl);
        almost_empty = (s_q.cnt <= aempty_lvl);

        // a full FIFO drops the write even if a read happens alongside
        push = push_req && !full;
        pop  = pop_req && !empty;

        if (push) begin
            s_d.wp = (s_q.wp == LAST_PTR) ? '0 : s_q.wp + 1'b1;
        end
        if (pop) begin
            s_d.rp = (s_q.rp == LAST_PTR) ? '0 : s_q.rp + 1'b1;
        end
        s_d.cnt = s_q.cnt + LW'(push) - LW'(pop);
        s_d.ovf = s_q.ovf | (push_req && full);
        s_d.udf = s_q.udf | (pop_req && empty);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_ptr    = s_q.wp;
    assign rd_ptr    = s_q.rp;
    assign overflow  = s_q.ovf;
    assign underflow = s_q.udf;

    // R5: occupancy never exceeds the depth
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_CNT);
    // R5: overflow is sticky
    a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R5: a write into a full FIFO without a read leaves it full
    a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop_req) |=> (full && $stable(s_q.wp)));
    // R6: underflow is sticky
    a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
    // R1: a lone accepted write adds one entry
    a_r1_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (s_q.cnt == $past(s_q.cnt) + LW'(1)));

endmodule

// File: rtl/txfifo_store.sv
module txfifo_store
    import txfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  entry_t        wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output entry_t        rdata
);

    entry_t mem_d [DEPTH];
    entry_t mem_q [DEPTH];
    entry_t out_d, out_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
        out_d = out_q;
        if (re) begin
            out_d = mem_q[raddr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            out_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
            out_q <= out_d;
        end
    end

    assign rdata = out_q;

    // R6: output holds when no read is taken
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));

endmodule

// File: rtl/tx_rate_fifo.sv
module tx_rate_fifo
    import txfifo_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int PACE_PERIOD = 33,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CTRL_W-1:0] wr_ctrl,
    input  logic              pace_en,
    input  logic              rd_en,
    input  logic [LW-1:0]     afull_lvl,
    input  logic [LW-1:0]     aempty_lvl,
    output logic [DATA_W-1:0] rd_data,
    output logic [CTRL_W-1:0] rd_ctrl,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty,
    output logic              overflow,
    output logic              underflow
);

    logic          wr_gated;
    logic          push;
    logic          pop;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    entry_t        wr_word;
    entry_t        rd_word;

    assign wr_word.ctrl = wr_ctrl;
    assign wr_word.data = wr_data;

    txfifo_pacer #(.PERIOD(PACE_PERIOD)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .pace_en (pace_en),
        .wr_req  (wr_en),
        .wr_ok   (wr_gated)
    );

    txfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_req     (wr_gated),
        .pop_req      (rd_en),
        .afull_lvl    (afull_lvl),
        .aempty_lvl   (aempty_lvl),
        .push         (push),
        .pop          (pop),
        .wr_ptr       (wr_ptr),
        .rd_ptr       (rd_ptr),
        .full         (full),
        .empty        (empty),
        .almost_full  (almost_full),
        .almost_empty (almost_empty),
        .overflow     (overflow),
        .underflow    (underflow)
    );

    txfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (push),
        .waddr (wr_ptr),
        .wdata (wr_word),
        .re    (pop),
        .raddr (rd_ptr),
        .rdata (rd_word)
    );

    assign rd_data = rd_word.data;
    assign rd_ctrl = rd_word.ctrl;

    // R2: full and empty are never both set
    a_r2_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    // R6: reading an empty FIFO leaves the outputs unchanged
    a_r6_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> ($stable(rd_data) && $stable(rd_ctrl)));

endmodule

// File: tb/tb_tx_rate_fifo.sv
module tb_tx_rate_fifo;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_ctrl = '0;
    logic        pace_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  afull_lvl = 5'd12;
    logic [4:0]  aempty_lvl = 5'd2;
    logic [63:0] rd_data;
    logic [7:0]  rd_ctrl;
    logic        full, empty, almost_full, almost_empty, overflow, underflow;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_rate_fifo dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_ctrl(wr_ctrl), .pace_en(pace_en), .rd_en(rd_en),
        .afull_lvl(afull_lvl), .aempty_lvl(aempty_lvl),
        .rd_data(rd_data), .rd_ctrl(rd_ctrl), .full(full), .empty(empty),
        .almost_full(almost_full), .almost_empty(almost_empty),
        .overflow(overflow), .underflow(underflow)
    );

    function automatic logic [71:0] word(input int k);
        return {8'(k * 7 + 1), 32'hA5C3_0000 | 32'(k), 32'(k * 3 + 5)};
    endfunction

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle, sample just after the edge
    task automatic step(input bit w, input logic [71:0] d, input bit r);
        @(negedge clk);
        wr_en   = w;
        wr_ctrl = d[71:64];
        wr_data = d[63:0];
        rd_en   = r;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; pace_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R2 empty", 72'(empty), 72'(1));
        check("R2 almost_empty", 72'(almost_empty), 72'(1));
        check("R2 full", 72'(full), 72'(0));
        check("R2 almost_full", 72'(almost_full), 72'(0));
        check("R2 sticky flags", 72'({overflow, underflow}), 72'(0));
        check("R2 read outputs", {rd_ctrl, rd_data}, 72'(0));
    endtask

    task automatic t_order_flags();
        do_reset();
        afull_lvl = 5'd5;
        aempty_lvl = 5'd1;
        for (int k = 0; k < 5; k++) begin
            step(1'b1, word(k), 1'b0);
            if (k == 1) check("R4 almost_empty off above level", 72'(almost_empty), 72'(0));
            if (k == 3) check("R3 almost_full below level", 72'(almost_full), 72'(0));
        end
        check("R3 almost_full at level", 72'(almost_full), 72'(1));
        for (int k = 0; k < 5; k++) begin
            step(1'b0, '0, 1'b1);
            check("R1 read order", {rd_ctrl, rd_data}, word(k));
            if (k == 0) check("R3 almost_full drops", 72'(almost_full), 72'(0));
            if (k == 3) check("R4 almost_empty at level", 72'(almost_empty), 72'(1));
        end
        check("R1 empty after drain", 72'(empty), 72'(1));
    endtask

    task automatic t_full_overflow();
        do_reset();
        afull_lvl = 5'd16;
        aempty_lvl = 5'd2;
        for (int k = 0; k < 16; k++) step(1'b1, word(100 + k), 1'b0);
        check("R5 full at 16", 72'(full), 72'(1));
        check("R3 almost_full at 16", 72'(almost_full), 72'(1));
        check("R5 no overflow yet", 72'(overflow), 72'(0));
        step(1'b1, word(999), 1'b0);
        check("R5 overflow set", 72'(overflow), 72'(1));
        // write with a read alongside while full is still dropped
        step(1'b1, word(998), 1'b1);
        check("R5 read while full", {rd_ctrl, rd_data}, word(100));
        check("R5 not full after read", 72'(full), 72'(0));
        for (int k = 1; k < 16; k++) begin
            step(1'b0, '0, 1'b1);
            check("R5 drain keeps order, dropped words absent", {rd_ctrl, rd_data}, word(100 + k));
            if (k == 13) check("R4 almost_empty at 2", 72'(almost_empty), 72'(1));
            if (k == 12) check("R4 almost_empty off at 3", 72'(almost_empty), 72'(0));
        end
        check("R5 empty after drain", 72'(empty), 72'(1));
        check("R5 overflow sticky", 72'(overflow), 72'(1));
        check("R6 underflow clear", 72'(underflow), 72'(0));
        step(1'b0, '0, 1'b1);
        check("R6 output held on empty read", {rd_ctrl, rd_data}, word(115));
        check("R6 underflow set", 72'(underflow), 72'(1));
        step(1'b0, '0, 1'b0);
        check("R6 underflow sticky", 72'(underflow), 72'(1));
    endtask

    task automatic t_pacer_gap();
        do_reset();
        pace_en = 1'b1;
        for (int k = 0; k < 30; k++) step(1'b0, '0, 1'b0);
        step(1'b1, word(200), 1'b0);   // count 30
        step(1'b1, word(201), 1'b0);   // count 31
        step(1'b1, word(202), 1'b0);   // count 32, closed
        step(1'b1, word(203), 1'b0);   // count 0
        pace_en = 1'b0;
        step(1'b0, '0, 1'b1);
        check("R7 slot 30 written", {rd_ctrl, rd_data}, word(200));
        step(1'b0, '0, 1'b1);
        check("R7 slot 31 written", {rd_ctrl, rd_data}, word(201));
        step(1'b0, '0, 1'b1);
        check("R7 slot 32 skipped", {rd_ctrl, rd_data}, word(203));
        check("R7 only three stored", 72'(empty), 72'(1));
    endtask

    task automatic t_unpaced_stream();
        do_reset();
        for (int k = 0; k < 100; k++) begin
            step(1'b1, word(300 + k), k >= 1);
            if (k >= 1) check("R8 continuous write", {rd_ctrl, rd_data}, word(299 + k));
        end
        step(1'b0, '0, 1'b1);
        check("R8 last word", {rd_ctrl, rd_data}, word(399));
        check("R8 no loss", 72'({overflow, underflow, empty}), 72'(1));
    endtask

    task automatic t_throttle();
        do_reset();
        afull_lvl = 5'd12;
        aempty_lvl = 5'd0;
        for (int k = 0; k < 20; k++) step(!almost_full, word(400 + k), 1'b0);
        check("R10 no overflow", 72'(overflow), 72'(0));
        check("R10 not full", 72'(full), 72'(0));
        for (int k = 0; k < 12; k++) begin
            step(1'b0, '0, 1'b1);
            check("R10 stored words", {rd_ctrl, rd_data}, word(400 + k));
            if (k == 10) check("R10 eleven read, not empty", 72'(empty), 72'(0));
        end
        check("R10 settled at level", 72'(empty), 72'(1));
    endtask

    task automatic t_paced_stream();
        int widx = 0;
        int ridx = 0;
        int occ  = 0;
        do_reset();
        pace_en = 1'b1;
        for (int k = 0; k < 33 * 40; k++) begin
            bit acc;
            bit r;
            bit rf;
            acc = (k % 33) != 32;
            r   = (k >= 4) && (((k - 4) % 33) != 32);
            rf  = r && (occ > 0);
            step(1'b1, word(1000 + widx), r);
            if (rf) begin
                check("R9 paced stream order", {rd_ctrl, rd_data}, word(1000 + ridx));
                ridx++;
            end
            if (acc) widx++;
            occ = occ + int'(acc) - int'(rf);
        end
        check("R9 no overflow or underflow", 72'({overflow, underflow}), 72'(0));
        pace_en = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_order_flags();
        t_full_overflow();
        t_pacer_gap();
        t_unpaced_stream();
        t_throttle();
        t_paced_stream();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule